// File: doc/BRIEF.md
# Serial Exception Coprocessor

This block is the exception and interrupt unit of a small RISC core built for minimum area. It holds four words of state: a status word with an interrupt enable and a saved copy of it, a cause word that records the kind of the last exception and whether it hit a branch delay slot, an exception PC, and a bad-address word. Every word is a shift register. The core loads it in parallel when an exception is taken, and software reaches it one bit per cycle, least significant bit first.

When the core reports a synchronous exception, the unit captures the context. It also does this when an enabled interrupt arrives at an instruction boundary. It saves the interrupt enable and clears it, then raises a one-cycle redirect that sends fetch to a fixed handler address. A return-from-exception strobe puts the saved enable back. Software reaches the words through a load/store style port: a start strobe with a word select and a write flag, followed by 32 serial cycles. Build-time switches remove each optional exception class. When a class is removed, its request line is ignored and its logic is not built.

Top module: `xcp_unit`

## Requirements
- R1: After reset, status, cause, exception PC and bad address all read 0, and `redirect` and `acc_busy` are 0.
- R2: A taken exception or interrupt sampled at a clock edge makes `redirect` 1 for exactly the following cycle. `vector_pc` always equals the parameter `VEC_ADDR` (default 32'h0000_0080).
- R3: On a taken event the exception PC becomes `pc_in`, or `pc_in - 4` when `in_delay` is 1. Cause bit 31 is set to `in_delay`.
- R4: On a taken event cause bits 6:2 get the class code and all other cause bits except bit 31 become 0. The codes are: load address error 4, store address error 5, reserved instruction 10, coprocessor unusable 11, overflow 12, interrupt 0. When several synchronous requests are present, priority runs load address error, store address error, reserved instruction, coprocessor unusable, overflow.
- R5: Status bit 0 is the interrupt enable and bit 2 is the saved enable. On entry, bit 2 takes the old bit 0 and bit 0 clears. On `rfe`, bit 0 takes bit 2. The other status bits are kept in both cases.
- R6: An interrupt is taken only when `irq`, `at_boundary` and status bit 0 are all 1 and no enabled synchronous request is present. A synchronous request wins over a pending interrupt.
- R7: The bad-address word loads `bad_addr` on an address error only. Any other taken event leaves it unchanged.
- R8: A serial access begins when `acc_start` is sampled while idle. Word selects are: 0 status, 1 cause, 2 exception PC, 3 bad address. `acc_busy` then stays 1 for exactly 32 cycles, and in the k-th of them `acc_sdo` shows bit k of the selected word. A read leaves the word unchanged.
- R9: A write to status replaces it with the 32 bits on `acc_sdi`, bit k sampled in the k-th busy cycle. Writes to the other words are ignored. An `acc_start` seen while busy is ignored.
- R10: With `EN_OVF`, `EN_CPU`, `EN_RI` or `EN_ADDR` set to 0, the matching requests cause no redirect and no state change. With `EN_ADDR` 0 the bad-address word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adel_req | input | 1 | Load address error from the core |
| ades_req | input | 1 | Store address error from the core |
| ri_req | input | 1 | Reserved instruction from the core |
| cpu_req | input | 1 | Coprocessor unusable from the core |
| ovf_req | input | 1 | Arithmetic overflow from the core |
| irq | input | 1 | External interrupt level |
| at_boundary | input | 1 | The core is between instructions |
| pc_in | input | 32 | PC of the current instruction |
| in_delay | input | 1 | The current instruction sits in a branch delay slot |
| bad_addr | input | 32 | Faulting data address |
| rfe | input | 1 | Return-from-exception strobe |
| acc_start | input | 1 | Start a serial access |
| acc_sel | input | 2 | Word select for the access |
| acc_wr | input | 1 | Access is a write |
| acc_sdi | input | 1 | Serial write data, LSB first |
| acc_sdo | output | 1 | Serial read data, LSB first |
| acc_busy | output | 1 | Serial access in progress |
| redirect | output | 1 | One-cycle fetch redirect |
| vector_pc | output | 32 | Handler address |

## Verification
The assertions assume that the core is stalled while `acc_busy` is 1. In that state it raises no exception request, no interrupt boundary and no `rfe`. They also assume that `rfe` is never raised in the same cycle as an exception. The stimulus keeps to this contract by issuing events and serial accesses one after another from separate tasks, never overlapping. Random request subsets, interrupt levels, delay-slot flags and status writes cover the priority and masking paths. Directed cases cover the removed classes and a start strobe given in the middle of an access.

// File: rtl/xcp_pkg.sv
package xcp_pkg;
  localparam int NREQ = 5;
  // request vector order, lowest index has highest priority
  localparam int IX_ADEL = 0;
  localparam int IX_ADES = 1;
  localparam int IX_RI   = 2;
  localparam int IX_CPU  = 3;
  localparam int IX_OVF  = 4;

  localparam logic [4:0] CODE_INT  = 5'd0;
  localparam logic [4:0] CODE_ADEL = 5'd4;
  localparam logic [4:0] CODE_ADES = 5'd5;
  localparam logic [4:0] CODE_RI   = 5'd10;
  localparam logic [4:0] CODE_CPU  = 5'd11;
  localparam logic [4:0] CODE_OVF  = 5'd12;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_EPC    = 2'd2,
    SEL_BADVA  = 2'd3
  } word_sel_e;

  function automatic logic [4:0] code_of(input int idx);
    case (idx)
      IX_ADEL: code_of = CODE_ADEL;
      IX_ADES: code_of = CODE_ADES;
      IX_RI:   code_of = CODE_RI;
      IX_CPU:  code_of = CODE_CPU;
      default: code_of = CODE_OVF;
    endcase
  endfunction
endpackage

// File: rtl/xcp_shreg.sv
module xcp_shreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         shift_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en)       q_nxt = load_val;
    else if (shift_en) q_nxt = {shift_in, q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   q <= '0;
    else if (load_en || shift_en) q <= q_nxt;
  end
endmodule

// File: rtl/xcp_arbiter.sv
module xcp_arbiter
  import xcp_pkg::*;
#(
  parameter logic [NREQ-1:0] EN_MASK = '1
) (
  input  logic [NREQ-1:0] req,
  input  logic            irq,
  input  logic            at_boundary,
  input  logic            ie,
  output logic            take,
  output logic [4:0]      code,
  output logic            is_addr
);
  logic [NREQ-1:0] req_m;
  logic            sync_any;

  assign req_m    = req & EN_MASK;
  assign sync_any = |req_m;

  always_comb begin
    code = CODE_INT;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req_m[i]) code = code_of(i);
    end
  end

  assign take    = sync_any || (irq && at_boundary && ie);
  assign is_addr = req_m[IX_ADEL] || req_m[IX_ADES];
endmodule

// File: rtl/xcp_seq.sv
module xcp_seq #(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] sel,
  input  logic       wr,
  output logic       busy,
  output logic [1:0] sel_q,
  output logic       wr_q
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          busy_nxt;
  logic [1:0]    sel_nxt;
  logic          wr_nxt;
  logic          upd_en;

  always_comb begin
    busy_nxt = busy;
    cnt_nxt  = cnt;
    sel_nxt  = sel_q;
    wr_nxt   = wr_q;
    if (!busy && start) begin
      busy_nxt = 1'b1;
      cnt_nxt  = '0;
      sel_nxt  = sel;
      wr_nxt   = wr;
    end else if (busy) begin
      cnt_nxt = cnt + 1'b1;
      if (cnt == LAST) busy_nxt = 1'b0;
    end
  end

  assign upd_en = busy || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      sel_q <= '0;
      wr_q  <= 1'b0;
    end else if (upd_en) begin
      busy  <= busy_nxt;
      cnt   <= cnt_nxt;
      sel_q <= sel_nxt;
      wr_q  <= wr_nxt;
    end
  end

  // R8: exactly W busy cycles per access
  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == LAST) |=> !busy);
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/xcp_unit.sv
module xcp_unit
  import xcp_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] VEC_ADDR = 32'h0000_0080,
  parameter bit          EN_OVF   = 1'b1,
  parameter bit          EN_CPU   = 1'b1,
  parameter bit          EN_RI    = 1'b1,
  parameter bit          EN_ADDR  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adel_req,
  input  logic              ades_req,
  input  logic              ri_req,
  input  logic              cpu_req,
  input  logic              ovf_req,
  input  logic              irq,
  input  logic              at_boundary,
  input  logic [DATA_W-1:0] pc_in,
  input  logic              in_delay,
  input  logic [DATA_W-1:0] bad_addr,
  input  logic              rfe,
  input  logic              acc_start,
  input  logic [1:0]        acc_sel,
  input  logic              acc_wr,
  input  logic              acc_sdi,
  output logic              acc_sdo,
  output logic              acc_busy,
  output logic              redirect,
  output logic [DATA_W-1:0] vector_pc
);
  localparam int BD_BIT = DATA_W - 1;
  localparam logic [NREQ-1:0] EN_MASK = {EN_OVF, EN_CPU, EN_RI, EN_ADDR, EN_ADDR};

  logic [NREQ-1:0]   req;
  logic              take, is_addr;
  logic [4:0]        code;
  logic [1:0]        sel_q;
  logic              wr_q;
  logic [DATA_W-1:0] status_q, cause_q, epc_q, badva_q;
  logic [DATA_W-1:0] status_ld, cause_ld, epc_ld;
  logic              status_le;
  logic [3:0]        shift_en;
  logic              redirect_nxt;

  assign req = {ovf_req, cpu_req, ri_req, ades_req, adel_req};
  assign vector_pc = DATA_W'(VEC_ADDR);

  xcp_arbiter #(.EN_MASK(EN_MASK)) u_arb (
    .req(req), .irq(irq), .at_boundary(at_boundary), .ie(status_q[0]),
    .take(take), .code(code), .is_addr(is_addr)
  );

  xcp_seq #(.W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(acc_start), .sel(acc_sel), .wr(acc_wr),
    .busy(acc_busy), .sel_q(sel_q), .wr_q(wr_q)
  );

  always_comb begin
    for (int i = 0; i < 4; i++) shift_en[i] = acc_busy && (sel_q == 2'(i));
  end

  // status: entry pushes the enable, rfe pops it
  always_comb begin
    status_ld = status_q;
    if (take) begin
      status_ld[2] = status_q[0];
      status_ld[0] = 1'b0;
    end else begin
      status_ld[0] = status_q[2];
    end
  end
  assign status_le = take || rfe;

  always_comb begin
    cause_ld         = '0;
    cause_ld[6:2]    = code;
    cause_ld[BD_BIT] = in_delay;
  end

  assign epc_ld = in_delay ? (pc_in - DATA_W'(4)) : pc_in;

  xcp_shreg #(.W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .load_en(status_le), .load_val(status_ld),
    .shift_en(shift_en[SEL_STATUS]), .shift_in(wr_q ? acc_sdi : status_q[0]),
    .q(status_q)
  );

  xcp_shreg #(.W(DATA_W)) u_cause (
    .clk(clk), .rst_n(rst_n), .load_en(take), .load_val(cause_ld),
    .shift_en(shift_en[SEL_CAUSE]), .shift_in(cause_q[0]), .q(cause_q)
  );

  xcp_shreg #(.W(DATA_W)) u_epc (
    .clk(clk), .rst_n(rst_n), .load_en(take), .load_val(epc_ld),
    .shift_en(shift_en[SEL_EPC]), .shift_in(epc_q[0]), .q(epc_q)
  );

  generate
    if (EN_ADDR) begin : g_badva
      xcp_shreg #(.W(DATA_W)) u_badva (
        .clk(clk), .rst_n(rst_n), .load_en(take && is_addr), .load_val(bad_addr),
        .shift_en(shift_en[SEL_BADVA]), .shift_in(badva_q[0]), .q(badva_q)
      );
    end else begin : g_no_badva
      assign badva_q = '0;
    end
  endgenerate

  always_comb begin
    case (sel_q)
      SEL_STATUS: acc_sdo = status_q[0];
      SEL_CAUSE:  acc_sdo = cause_q[0];
      SEL_EPC:    acc_sdo = epc_q[0];
      default:    acc_sdo = badva_q[0];
    endcase
    if (!acc_busy) acc_sdo = 1'b0;
  end

  assign redirect_nxt = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redirect <= 1'b0;
    else        redirect <= redirect_nxt;
  end

  // R2: a taken event redirects on the next cycle
  p_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> redirect);
  // R5: the enable is off while the handler is entered
  p_ie_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !status_q[0]);
  // R6: an interrupt entry requires the enable before entry
  p_int_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && cause_q[6:2] == CODE_INT) |-> $past(status_q[0]));
  // R6: a present enabled synchronous request never yields an interrupt code
  p_sync_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((EN_ADDR && (adel_req || ades_req)) || (EN_RI && ri_req)) |=>
      (redirect && cause_q[6:2] != CODE_INT));
  // R3: exception PC outside a delay slot
  p_epc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_delay) |=> (epc_q == $past(pc_in)));
endmodule

// File: tb/sim_xcp_unit.sv
`timescale 1ns/1ps
module sim_xcp_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic adel_req, ades_req, ri_req, cpu_req, ovf_req, irq, at_boundary, in_delay, rfe;
  logic [31:0] pc_in, bad_addr;
  logic acc_start, acc_wr, acc_sdi;
  logic [1:0] acc_sel;
  logic sdo0, busy0, redir0, sdo1, busy1, redir1;
  logic [31:0] vec0, vec1;

  int total = 0;
  int bad = 0;
  logic [31:0] m_status, m_cause, m_epc, m_bad;

  always #2 clk = ~clk;

  xcp_unit u0 (
    .clk(clk), .rst_n(rst_n), .adel_req(adel_req), .ades_req(ades_req), .ri_req(ri_req),
    .cpu_req(cpu_req), .ovf_req(ovf_req), .irq(irq), .at_boundary(at_boundary),
    .pc_in(pc_in), .in_delay(in_delay), .bad_addr(bad_addr), .rfe(rfe),
    .acc_start(acc_start), .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_sdi(acc_sdi),
    .acc_sdo(sdo0), .acc_busy(busy0), .redirect(redir0), .vector_pc(vec0)
  );

  xcp_unit #(.EN_OVF(1'b0), .EN_ADDR(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .adel_req(adel_req), .ades_req(ades_req), .ri_req(ri_req),
    .cpu_req(cpu_req), .ovf_req(ovf_req), .irq(irq), .at_boundary(at_boundary),
    .pc_in(pc_in), .in_delay(in_delay), .bad_addr(bad_addr), .rfe(rfe),
    .acc_start(acc_start), .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_sdi(acc_sdi),
    .acc_sdo(sdo1), .acc_busy(busy1), .redirect(redir1), .vector_pc(vec1)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R4 priority and codes: adel 4, ades 5, ri 10, cpu 11, ovf 12
  function automatic logic [4:0] exp_code(input logic [4:0] rq);
    if (rq[0])      return 5'd4;
    else if (rq[1]) return 5'd5;
    else if (rq[2]) return 5'd10;
    else if (rq[3]) return 5'd11;
    else if (rq[4]) return 5'd12;
    return 5'd0;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // rq bit order: 0 adel, 1 ades, 2 ri, 3 cpu, 4 ovf
  task automatic do_event(input logic [4:0] rq, input bit ir, input bit bd,
                          input logic [31:0] pc, input bit dl, input logic [31:0] ba,
                          input bit check_u1_quiet);
    bit tk;
    logic [4:0] cd;
    {ovf_req, cpu_req, ri_req, ades_req, adel_req} = rq;
    irq = ir; at_boundary = bd; pc_in = pc; in_delay = dl; bad_addr = ba;
    tk = (rq != 0) || (ir && bd && m_status[0]);
    cd = exp_code(rq);
    tick();
    chk(redir0 == tk, "R2/R6 redirect", 32'(redir0), 32'(tk));
    if (check_u1_quiet) chk(redir1 == 1'b0, "R10 removed class redirect", 32'(redir1), 32'h0);
    {ovf_req, cpu_req, ri_req, ades_req, adel_req} = '0;
    irq = 1'b0; at_boundary = 1'b0; in_delay = 1'b0;
    if (tk) begin
      m_epc = dl ? pc - 32'd4 : pc;
      m_cause = '0; m_cause[6:2] = cd; m_cause[31] = dl;
      if (cd == 5'd4 || cd == 5'd5) m_bad = ba;
      m_status[2] = m_status[0];
      m_status[0] = 1'b0;
    end
    tick();
    chk(redir0 == 1'b0, "R2 single-cycle redirect", 32'(redir0), 32'h0);
  endtask

  task automatic do_rfe();
    rfe = 1'b1;
    tick();
    rfe = 1'b0;
    m_status[0] = m_status[2];
  endtask

  task automatic do_access(input bit inst, input logic [1:0] sel, input bit wr,
                           input logic [31:0] wd, input bit poke, output logic [31:0] rd);
    acc_start = 1'b1; acc_sel = sel; acc_wr = wr;
    tick();
    acc_start = 1'b0; acc_wr = 1'b0;
    for (int k = 0; k < 32; k++) begin
      acc_sdi = wd[k];
      rd[k] = inst ? sdo1 : sdo0;
      if (k == 0 || k == 31) chk((inst ? busy1 : busy0) == 1'b1, "R8 busy held", 32'(busy0), 32'h1);
      if (poke && k == 5) begin
        acc_start = 1'b1; acc_sel = sel ^ 2'd1; acc_wr = 1'b1;
      end
      tick();
      acc_start = 1'b0; acc_wr = 1'b0; acc_sel = sel;
    end
    chk((inst ? busy1 : busy0) == 1'b0, "R8 busy ends after 32", 32'(busy0), 32'h0);
    acc_sdi = 1'b0;
  endtask

  function automatic logic [31:0] model_of(input logic [1:0] sel);
    case (sel)
      2'd0: return m_status;
      2'd1: return m_cause;
      2'd2: return m_epc;
      default: return m_bad;
    endcase
  endfunction

  task automatic read_chk(input logic [1:0] sel, input string req);
    logic [31:0] rd;
    do_access(1'b0, sel, 1'b0, 32'h0, 1'b0, rd);
    chk(rd == model_of(sel), req, rd, model_of(sel));
  endtask

  task automatic write_status(input logic [31:0] v);
    logic [31:0] rd;
    do_access(1'b0, 2'd0, 1'b1, v, 1'b0, rd);
    chk(rd == m_status, "R8 old status shifted out", rd, m_status);
    m_status = v;
    read_chk(2'd0, "R9 status write");
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    {adel_req, ades_req, ri_req, cpu_req, ovf_req, irq, at_boundary, in_delay, rfe} = '0;
    pc_in = '0; bad_addr = '0; acc_start = 1'b0; acc_wr = 1'b0; acc_sdi = 1'b0; acc_sel = '0;
    m_status = '0; m_cause = '0; m_epc = '0; m_bad = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(redir0 == 1'b0 && busy0 == 1'b0, "R1 outputs idle", {30'h0, redir0, busy0}, 32'h0);
    for (int s = 0; s < 4; s++) read_chk(2'(s), "R1 reset word");
    chk(vec0 == 32'h0000_0080, "R2 vector", vec0, 32'h80);

    // R10 removed overflow and address error on u1; u0 still takes them
    do_event(5'b10000, 1'b0, 1'b0, 32'h0000_1000, 1'b0, 32'h0, 1'b1);
    do_event(5'b00001, 1'b0, 1'b0, 32'h0000_2000, 1'b0, 32'hDEAD_BEE1, 1'b1);
    do_access(1'b1, 2'd3, 1'b0, 32'h0, 1'b0, rd);
    chk(rd == 32'h0, "R10 bad address absent", rd, 32'h0);
    do_access(1'b1, 2'd1, 1'b0, 32'h0, 1'b0, rd);
    chk(rd == 32'h0, "R10 cause untouched", rd, 32'h0);
    read_chk(2'd3, "R7 bad address captured");
    read_chk(2'd1, "R4 load address error code");

    // R6 masked interrupt, then enabled interrupt in a delay slot
    do_event(5'b0, 1'b1, 1'b1, 32'h0000_3000, 1'b0, 32'h0, 1'b0);
    write_status(32'h0000_0001);
    do_event(5'b0, 1'b1, 1'b0, 32'h0000_3004, 1'b0, 32'h0, 1'b0);
    do_event(5'b0, 1'b1, 1'b1, 32'h0000_3008, 1'b1, 32'h0, 1'b0);
    read_chk(2'd1, "R3 delay flag and R6 interrupt code");
    read_chk(2'd2, "R3 delay-slot PC");
    read_chk(2'd0, "R5 enable pushed");
    do_rfe();
    read_chk(2'd0, "R5 enable restored");

    // R6 synchronous wins over an enabled interrupt; R7 non-address keeps bad address
    do_event(5'b01000, 1'b1, 1'b1, 32'h0000_4000, 1'b0, 32'h1111_1111, 1'b0);
    read_chk(2'd1, "R6 sync first");
    read_chk(2'd3, "R7 unchanged on other class");

    // R9 writes to read-only words ignored; start while busy ignored
    do_access(1'b0, 2'd2, 1'b1, 32'hFFFF_FFFF, 1'b0, rd);
    read_chk(2'd2, "R9 exception PC write ignored");
    do_access(1'b0, 2'd1, 1'b0, 32'h0, 1'b1, rd);
    chk(rd == m_cause, "R9 start while busy ignored", rd, m_cause);
    read_chk(2'd0, "R9 status not hit by ignored start");

    // random phase
    for (int it = 0; it < 120; it++) begin
      int op;
      op = int'($urandom % 4);
      if (op == 0) begin
        logic [4:0] rq;
        rq = 5'($urandom);
        if ($urandom % 2) rq = '0;
        do_event(rq, 1'($urandom), 1'($urandom), {$urandom} & 32'hFFFF_FFFC,
                 1'($urandom), $urandom, 1'b0);
      end else if (op == 1) begin
        write_status($urandom);
      end else if (op == 2) begin
        do_rfe();
      end else begin
        read_chk(2'($urandom), "R8 random read");
      end
    end
    for (int s = 0; s < 4; s++) read_chk(2'(s), "R4 final state");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule